// File: doc/BRIEF.md
# Interrupt and DMA Request Router

This block gathers thirteen event sources from the neighbouring data-path, command and clock logic into a sticky request register. Each source has a set input and a clear input. A bit set in the mask register blocks its source from the processor. The block drives one processor interrupt line, which goes high when any request bit not covered by the effective mask is pending.

The receive and transmit FIFO service requests have their own pair of request lines toward a DMA engine. These two lines follow their request bits whatever the mask holds. When the DMA enable input is high, both FIFO request bits are added to the effective mask. They then reach only the DMA lines and stop raising the processor interrupt. The software-written mask register is not changed by this.

All three outputs come from flip-flops. They reflect the request register, the mask register and the DMA enable as they stood one clock earlier.

Top module: `irq_dma_router`

## Requirements
- R1: While `rst` is high at a clock edge, the request register and the mask register clear to zero, and `cpu_irq`, `rx_dreq` and `tx_dreq` go low.
- R2: Request bit indices are: 0 data done, 1 program done, 2 end of command, 3 stop command, 4 clock off, 5 receive FIFO service, 6 transmit FIFO service, 7 timer, 8 data error, 9 response error, 10 read stalled, 11 card interrupt, 12 card acknowledge. At a clock edge, `evt_set[i]` high makes request bit i one, and `evt_clr[i]` high with `evt_set[i]` low makes it zero. Set wins when both are high. A bit with neither input high holds its value. The register is visible on `req_view`.
- R3: A clock edge with `mask_we` high loads all 13 bits of `mask_wdata` into the mask register. With `mask_we` low the mask holds. The register is visible on `mask_view`.
- R4: With `dma_en` low, `cpu_irq` is high exactly when some request bit is set whose mask bit is zero. A mask bit of one blocks its source.
- R5: With `dma_en` high, request bits 5 and 6 are treated as masked for `cpu_irq`. All other bits still follow the mask register.
- R6: `rx_dreq` follows request bit 5 and `tx_dreq` follows request bit 6. Neither the mask register nor `dma_en` affects them.
- R7: Outputs are registered. A change to the request register, the mask register or `dma_en` shows on the outputs at the following clock edge. Because of this, an event input reaches `cpu_irq` two edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | 13 | Per-source set strobes |
| evt_clr | input | 13 | Per-source clear strobes |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 13 | Mask register write data |
| dma_en | input | 1 | Steer FIFO requests to DMA only |
| cpu_irq | output | 1 | Processor interrupt request |
| rx_dreq | output | 1 | Receive FIFO DMA request |
| tx_dreq | output | 1 | Transmit FIFO DMA request |
| req_view | output | 13 | Current request register |
| mask_view | output | 13 | Current mask register |

## Verification
The interrupt path is driven with several patterns:
- A single pending error bit under a full mask, an all-but-that-bit mask, and a mask of only that bit. These separate blocking from pass-through.
- Pending FIFO bits with `dma_en` toggled and the mask cleared. This shows that steering hides only bits 5 and 6, since a data-done bit pending at the same time still raises the interrupt.
- A mask covering the FIFO bits with `dma_en` low. This shows that the DMA lines ignore the mask.
- Coincident set and clear strobes, and a sample taken one edge after a mask or request change. These pin down set priority and the single register stage on the outputs.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int NUM_SRC = 13;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    localparam int SRC_DATA_DONE = 0;
    localparam int SRC_PROG_DONE = 1;
    localparam int SRC_CMD_END   = 2;
    localparam int SRC_STOP_CMD  = 3;
    localparam int SRC_CLK_OFF   = 4;
    localparam int SRC_RX_SVC    = 5;
    localparam int SRC_TX_SVC    = 6;
    localparam int SRC_TIMER     = 7;
    localparam int SRC_DATA_ERR  = 8;
    localparam int SRC_RESP_ERR  = 9;
    localparam int SRC_RD_STALL  = 10;
    localparam int SRC_CARD_INT  = 11;
    localparam int SRC_CARD_ACK  = 12;

    localparam src_vec_t FIFO_SRCS = src_vec_t'((1 << SRC_RX_SVC) | (1 << SRC_TX_SVC));

    typedef struct packed {
        logic irq;
        logic rx;
        logic tx;
    } route_out_t;

    function automatic src_vec_t eff_mask(input src_vec_t sw_mask, input logic dma_on);
        return dma_on ? (sw_mask | FIFO_SRCS) : sw_mask;
    endfunction

endpackage

// File: rtl/irq_req_reg.sv
module irq_req_reg
    import irq_route_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    output src_vec_t req_q
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                req_q[i] <= 1'b0;
            else if (set_i[i])
                req_q[i] <= 1'b1;
            else if (clr_i[i])
                req_q[i] <= 1'b0;
        end
    end

    p_set_wins_r2: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((req_q & $past(set_i)) == $past(set_i)));

    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        ((clr_i & ~set_i) != '0) |=> ((req_q & $past(clr_i & ~set_i)) == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        ((set_i | clr_i) == '0) |=> $stable(req_q));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_route_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we_i,
    input  src_vec_t wdata_i,
    output src_vec_t mask_q
);

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (we_i)
            mask_q <= wdata_i;
    end

    p_mask_load_r3: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (mask_q == $past(wdata_i)));

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(mask_q));

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
    import irq_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  src_vec_t   req_i,
    input  src_vec_t   mask_i,
    input  logic       dma_on_i,
    output route_out_t out_q
);

    route_out_t nxt;

    always_comb begin
        nxt.irq = |(req_i & ~eff_mask(mask_i, dma_on_i));
        nxt.rx  = req_i[SRC_RX_SVC];
        nxt.tx  = req_i[SRC_TX_SVC];
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else
            out_q <= nxt;
    end

    p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        ((req_i & ~mask_i) == '0) |=> !out_q.irq);

    p_raise_r4: assert property (@(posedge clk) disable iff (rst)
        (!dma_on_i && ((req_i & ~mask_i) != '0)) |=> out_q.irq);

    p_dma_hides_fifo_r5: assert property (@(posedge clk) disable iff (rst)
        (dma_on_i && ((req_i & ~mask_i & ~FIFO_SRCS) == '0)) |=> !out_q.irq);

    p_rx_follow_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_q.rx == $past(req_i[SRC_RX_SVC])));

    p_tx_follow_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_q.tx == $past(req_i[SRC_TX_SVC])));

endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router
    import irq_route_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_set,
    input  logic [NUM_SRC-1:0] evt_clr,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic               dma_en,
    output logic               cpu_irq,
    output logic               rx_dreq,
    output logic               tx_dreq,
    output logic [NUM_SRC-1:0] req_view,
    output logic [NUM_SRC-1:0] mask_view
);

    src_vec_t   req_q;
    src_vec_t   mask_q;
    route_out_t route_q;

    irq_req_reg u_req (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt_set),
        .clr_i (evt_clr),
        .req_q (req_q)
    );

    irq_mask_reg u_mask (
        .clk     (clk),
        .rst     (rst),
        .we_i    (mask_we),
        .wdata_i (mask_wdata),
        .mask_q  (mask_q)
    );

    irq_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_q),
        .mask_i   (mask_q),
        .dma_on_i (dma_en),
        .out_q    (route_q)
    );

    assign cpu_irq   = route_q.irq;
    assign rx_dreq   = route_q.rx;
    assign tx_dreq   = route_q.tx;
    assign req_view  = req_q;
    assign mask_view = mask_q;

    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!cpu_irq && !rx_dreq && !tx_dreq && req_q == '0 && mask_q == '0));

endmodule

// File: tb/irq_dma_router_bench.sv
`timescale 1ns/1ps
module irq_dma_router_bench;
    localparam int N = 13;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] evt_set = '0;
    logic [N-1:0] evt_clr = '0;
    logic         mask_we = 1'b0;
    logic [N-1:0] mask_wdata = '0;
    logic         dma_en = 1'b0;
    logic         cpu_irq, rx_dreq, tx_dreq;
    logic [N-1:0] req_view, mask_view;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_dma_router u_irq_dma_router (
        .clk        (clk),
        .rst        (rst),
        .evt_set    (evt_set),
        .evt_clr    (evt_clr),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .dma_en     (dma_en),
        .cpu_irq    (cpu_irq),
        .rx_dreq    (rx_dreq),
        .tx_dreq    (tx_dreq),
        .req_view   (req_view),
        .mask_view  (mask_view)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [N-1:0] s, input logic [N-1:0] c);
        evt_set = s;
        evt_clr = c;
        tick();
        evt_set = '0;
        evt_clr = '0;
    endtask

    task automatic wr_mask(input logic [N-1:0] v);
        mask_we = 1'b1;
        mask_wdata = v;
        tick();
        mask_we = 1'b0;
    endtask

    task automatic outs(input string tag, input logic i, input logic r, input logic t);
        chk({tag, " irq"}, 32'(cpu_irq), 32'(i));
        chk({tag, " rx"}, 32'(rx_dreq), 32'(r));
        chk({tag, " tx"}, 32'(tx_dreq), 32'(t));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        chk("R1 req", 32'(req_view), 0);
        chk("R1 mask", 32'(mask_view), 0);
        outs("R1", 0, 0, 0);
    endtask

    task automatic t_set_clear();
        pulse(13'h0408, '0);
        tick();
        chk("R2 set req", 32'(req_view), 32'h408);
        outs("R4 unmasked", 1, 0, 0);
        pulse('0, 13'h0008);
        tick();
        chk("R2 clear one", 32'(req_view), 32'h400);
        pulse('0, 13'h0400);
        tick();
        chk("R2 clear all", 32'(req_view), 0);
        outs("R4 empty", 0, 0, 0);
    endtask

    task automatic t_priority();
        pulse(13'h0080, 13'h0080);
        tick();
        chk("R2 set wins", 32'(req_view), 32'h80);
        pulse('0, 13'h1FFF);
        tick();
        chk("R2 cleanup", 32'(req_view), 0);
    endtask

    task automatic t_mask();
        pulse(13'h0200, '0);
        wr_mask(13'h1FFF);
        tick();
        chk("R3 mask full", 32'(mask_view), 32'h1FFF);
        outs("R4 full mask", 0, 0, 0);
        wr_mask(13'h1DFF);
        tick();
        chk("R3 mask load", 32'(mask_view), 32'h1DFF);
        chk("R4 bit open", 32'(cpu_irq), 1);
        wr_mask(13'h0200);
        tick();
        chk("R4 own bit masked", 32'(cpu_irq), 0);
        pulse('0, 13'h1FFF);
        wr_mask('0);
        tick();
    endtask

    task automatic t_dma();
        pulse(13'h0020, '0);
        tick();
        outs("R6 rx no dma", 1, 1, 0);
        dma_en = 1'b1;
        tick();
        outs("R5 rx hidden", 0, 1, 0);
        pulse(13'h0040, '0);
        tick();
        outs("R5 tx hidden", 0, 1, 1);
        pulse(13'h0001, '0);
        tick();
        chk("R5 other bit passes", 32'(cpu_irq), 1);
        chk("R5 mask untouched", 32'(mask_view), 0);
        pulse('0, 13'h0001);
        tick();
        chk("R5 fifo only", 32'(cpu_irq), 0);
        dma_en = 1'b0;
        tick();
        chk("R5 dma off", 32'(cpu_irq), 1);
        wr_mask(13'h0060);
        tick();
        outs("R6 mask ignores dreq", 0, 1, 1);
        pulse('0, 13'h1FFF);
        wr_mask('0);
        tick();
        outs("R6 drained", 0, 0, 0);
    endtask

    task automatic t_latency();
        wr_mask(13'h0001);
        pulse(13'h0001, '0);
        chk("R7 req now", 32'(req_view), 1);
        chk("R7 masked", 32'(cpu_irq), 0);
        mask_we = 1'b1;
        mask_wdata = '0;
        tick();
        mask_we = 1'b0;
        chk("R7 mask now", 32'(mask_view), 0);
        chk("R7 irq lags mask", 32'(cpu_irq), 0);
        tick();
        chk("R7 irq after", 32'(cpu_irq), 1);
        pulse('0, 13'h0001);
        chk("R7 req cleared", 32'(req_view), 0);
        chk("R7 irq lags req", 32'(cpu_irq), 1);
        tick();
        chk("R7 irq drops", 32'(cpu_irq), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_priority();
        t_mask();
        t_dma();
        t_latency();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule